// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block sits between the register file of a memory-card host controller and its card-side engine. A write to the command register is masked and stored. The block then decodes the command index, the data-present flag, the expected response kind and the data direction. If no earlier command is still outstanding, it hands the index and the argument to the card engine as a one-cycle request. When a transfer is attached to the command, it also starts the data path and latches the direction.

The card engine answers with a byte count and up to sixteen response bytes, first byte in the most significant position. The block checks that the count is long enough for the requested response kind, packs the bytes into four 32-bit response words, and screens the card status against an error mask that depends on the command. It then emits one-cycle event pulses for the interrupt logic: completion, timeout, and card-error set or clear. A response kind that carries busy holds completion back until the card releases its data line. A reset command issued while the controller is in initialisation mode completes at once, with no card exchange.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: A command write is accepted only while `cmd_inhibit` is low. On acceptance, `cmd_q` becomes `cmd_wdata & 32'h3FFB0037`. A write while `cmd_inhibit` is high leaves `cmd_q` unchanged and raises no `card_req`.
- R2: An accepted command that is not an init bypass pulses `card_req` for one cycle, in the cycle after the write. It presents `card_idx` = write bits 29:24 and `card_arg` = `arg_in`. `cmd_inhibit` then stays high until completion or timeout.
- R3: If `init_mode` is high and the index is 0, the write produces `ev_cc` in the next cycle. It raises no `card_req`, and `cmd_inhibit` stays low.
- R4: Response kind is write bits 17:16 (0 none, 1 long, 2 short, 3 short with busy). For a long response with a count of at least 16, `resp_words` takes all sixteen bytes. Byte 0 of the response lands at bits 127:120 and byte 15 at bits 7:0.
- R5: For a short response, with or without busy, and a count of at least 4, bytes 0..3 go into bits 31:0, byte 0 on top. Bits 127:32 keep their value. The response words change only in the cycle after an accepted response.
- R6: A long response with fewer than 16 bytes, or a short one with fewer than 4, gives `ev_cto` instead of `ev_cc` and leaves `resp_words` unchanged. Kind 0 never times out and captures nothing.
- R7: For kinds 0, 1 and 2 without timeout, `ev_cc` pulses in the cycle after the response is accepted, and `cmd_inhibit` falls in that same cycle.
- R8: For kind 3 without timeout, `busy_flag` rises after the response. `ev_cc` is withheld while `card_busy` is high and pulses in the cycle after `card_busy` is first seen low. `busy_flag` and `cmd_inhibit` fall together with that pulse.
- R9: With every accepted response, exactly one of `ev_cerr_set` and `ev_cerr_clr` pulses. The set pulse occurs when the checked status AND the mask AND `err_en` is nonzero. Indexes 41 and 8 are never checked. Index 3 checks response bits 15:0 of the first word against mask 0x00000E00. Every other index checks the full first word against mask 0xFDF98000. Only short kinds without timeout are checked.
- R10: A command with data present (bit 21) pulses `xfer_start` together with `card_req` and loads `xfer_dir_rd` from bit 4. A command without data present leaves `xfer_dir_rd` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command register write data |
| arg_in | input | 32 | Argument register value |
| err_en | input | 32 | Card error-enable register |
| init_mode | input | 1 | Controller initialisation mode bit |
| rsp_valid | input | 1 | Card engine response strobe |
| rsp_count | input | 5 | Number of response bytes returned |
| rsp_data | input | 128 | Response bytes, byte 0 in bits 127:120 |
| card_busy | input | 1 | Card holds its data line busy |
| cmd_q | output | 32 | Stored, masked command register |
| card_req | output | 1 | One-cycle command request to the card engine |
| card_idx | output | 6 | Command index presented to the card engine |
| card_arg | output | 32 | Argument presented to the card engine |
| resp_words | output | 128 | Four response words, word i at bits 32i+31:32i |
| xfer_start | output | 1 | One-cycle data transfer start |
| xfer_dir_rd | output | 1 | Latched transfer direction, 1 = card to host |
| busy_flag | output | 1 | Waiting for busy release |
| cmd_inhibit | output | 1 | Command outstanding |
| ev_cc | output | 1 | Command-complete event pulse |
| ev_cto | output | 1 | Command-timeout event pulse |
| ev_cerr_set | output | 1 | Card-error event pulse |
| ev_cerr_clr | output | 1 | Card-error clear pulse |

## Verification
The busy release and a new command write can land in the same clock edge. At that edge the command is still outstanding, so the write must be dropped even though `ev_cc` is about to pulse. The bench provokes this by lowering `card_busy` and raising `cmd_wr` in the same cycle. It then judges that `ev_cc` appears while `cmd_q` holds its old value and no `card_req` follows. A second overlap, the card-error verdict arriving in the same cycle as completion, is judged by checking both pulses after every response.

// File: rtl/cmd_issue_pkg.sv
package cmd_issue_pkg;

  localparam logic [31:0] CMD_KEEP_MASK   = 32'h3FFB_0037;
  localparam logic [31:0] STD_ERR_MASK    = 32'hFDF9_8000;
  localparam logic [31:0] ADDR_RSP_MASK   = 32'h0000_0E00;
  localparam logic [5:0]  IDX_ADDR_RSP    = 6'd3;
  localparam logic [5:0]  IDX_IF_COND     = 6'd8;
  localparam logic [5:0]  IDX_OP_COND     = 6'd41;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_LONG       = 2'd1,
    RSP_SHORT      = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_t;

  typedef struct packed {
    logic [5:0] idx;
    logic       data_present;
    rsp_kind_t  kind;
    logic       dir_rd;
  } cmd_fields_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_issue_pkg::*;
#(
  parameter int CMD_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CMD_W-1:0] wdata,
  output logic [CMD_W-1:0] cmd_q,
  output cmd_fields_t      fields
);

  always_comb begin
    fields.idx          = wdata[29:24];
    fields.data_present = wdata[21];
    fields.kind         = rsp_kind_t'(wdata[17:16]);
    fields.dir_rd       = wdata[4];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cmd_q <= '0;
    else if (load)
      cmd_q <= wdata & CMD_KEEP_MASK;
  end

endmodule

// File: rtl/rsp_capture.sv
module rsp_capture
  import cmd_issue_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int RSP_BYTES = 16,
  parameter int CNT_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   accept,
  input  rsp_kind_t              kind,
  input  logic [CNT_W-1:0]       count,
  input  logic [RSP_BYTES*8-1:0] data,
  output logic [RSP_BYTES*8-1:0] words,
  output logic                   timed_out
);

  localparam int RSP_W = RSP_BYTES * 8;
  localparam int WORDS = RSP_W / DATA_W;
  localparam logic [CNT_W-1:0] NEED_LONG  = CNT_W'(RSP_BYTES);
  localparam logic [CNT_W-1:0] NEED_SHORT = CNT_W'(DATA_W / 8);

  logic [WORDS-1:0][DATA_W-1:0] word_q;
  logic                         do_store;

  always_comb begin
    unique case (kind)
      RSP_LONG:                 timed_out = (count < NEED_LONG);
      RSP_SHORT, RSP_SHORT_BUSY: timed_out = (count < NEED_SHORT);
      default:                  timed_out = 1'b0;
    endcase
  end

  assign do_store = accept && !timed_out;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[i] <= '0;
      else if (do_store) begin
        if (kind == RSP_LONG)
          word_q[i] <= data[i*DATA_W +: DATA_W];
        else if ((i == 0) && (kind == RSP_SHORT || kind == RSP_SHORT_BUSY))
          word_q[i] <= data[RSP_W-1 -: DATA_W];
      end
    end
  end

  assign words = word_q;

endmodule

// File: rtl/card_err_check.sv
module card_err_check
  import cmd_issue_pkg::*;
(
  input  logic [5:0]  idx,
  input  rsp_kind_t   kind,
  input  logic        timed_out,
  input  logic [31:0] status_word,
  input  logic [31:0] err_en,
  output logic        err_hit
);

  logic [31:0] mask;
  logic [31:0] status;

  always_comb begin
    mask   = '0;
    status = '0;
    if (!timed_out && (kind == RSP_SHORT || kind == RSP_SHORT_BUSY)) begin
      if (idx == IDX_OP_COND || idx == IDX_IF_COND) begin
        mask   = '0;
        status = '0;
      end else if (idx == IDX_ADDR_RSP) begin
        mask   = ADDR_RSP_MASK;
        status = {16'h0000, status_word[15:0]};
      end else begin
        mask   = STD_ERR_MASK;
        status = status_word;
      end
    end
    err_hit = |(status & mask & err_en);
  end

endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl
  import cmd_issue_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int DATA_W    = 32,
  parameter int RSP_BYTES = 16,
  parameter int IDX_W     = 6,
  parameter int CNT_W     = $clog2(RSP_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_wr,
  input  logic [CMD_W-1:0]       cmd_wdata,
  input  logic [DATA_W-1:0]      arg_in,
  input  logic [DATA_W-1:0]      err_en,
  input  logic                   init_mode,
  input  logic                   rsp_valid,
  input  logic [CNT_W-1:0]       rsp_count,
  input  logic [RSP_BYTES*8-1:0] rsp_data,
  input  logic                   card_busy,
  output logic [CMD_W-1:0]       cmd_q,
  output logic                   card_req,
  output logic [IDX_W-1:0]       card_idx,
  output logic [DATA_W-1:0]      card_arg,
  output logic [RSP_BYTES*8-1:0] resp_words,
  output logic                   xfer_start,
  output logic                   xfer_dir_rd,
  output logic                   busy_flag,
  output logic                   cmd_inhibit,
  output logic                   ev_cc,
  output logic                   ev_cto,
  output logic                   ev_cerr_set,
  output logic                   ev_cerr_clr
);

  localparam int RSP_W = RSP_BYTES * 8;

  ctl_state_t  state_q;
  cmd_fields_t fields;
  rsp_kind_t   kind_q;
  logic        accept_cmd;
  logic        accept_rsp;
  logic        timed_out;
  logic        err_hit;
  logic        init_bypass;

  assign accept_cmd  = cmd_wr && (state_q == ST_IDLE);
  assign accept_rsp  = rsp_valid && (state_q == ST_WAIT);
  assign init_bypass = init_mode && (fields.idx == '0);

  cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .load   (accept_cmd),
    .wdata  (cmd_wdata),
    .cmd_q  (cmd_q),
    .fields (fields)
  );

  rsp_capture #(
    .DATA_W    (DATA_W),
    .RSP_BYTES (RSP_BYTES),
    .CNT_W     (CNT_W)
  ) u_cap (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept_rsp),
    .kind      (kind_q),
    .count     (rsp_count),
    .data      (rsp_data),
    .words     (resp_words),
    .timed_out (timed_out)
  );

  card_err_check u_err (
    .idx         (card_idx),
    .kind        (kind_q),
    .timed_out   (timed_out),
    .status_word (rsp_data[RSP_W-1 -: 32]),
    .err_en      (err_en),
    .err_hit     (err_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      kind_q      <= RSP_NONE;
      card_req    <= 1'b0;
      card_idx    <= '0;
      card_arg    <= '0;
      xfer_start  <= 1'b0;
      xfer_dir_rd <= 1'b0;
      busy_flag   <= 1'b0;
      ev_cc       <= 1'b0;
      ev_cto      <= 1'b0;
      ev_cerr_set <= 1'b0;
      ev_cerr_clr <= 1'b0;
    end else begin
      card_req    <= 1'b0;
      xfer_start  <= 1'b0;
      ev_cc       <= 1'b0;
      ev_cto      <= 1'b0;
      ev_cerr_set <= 1'b0;
      ev_cerr_clr <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_cmd) begin
            if (init_bypass) begin
              ev_cc <= 1'b1;
            end else begin
              card_req <= 1'b1;
              card_idx <= fields.idx;
              card_arg <= arg_in;
              kind_q   <= fields.kind;
              state_q  <= ST_WAIT;
              if (fields.data_present) begin
                xfer_start  <= 1'b1;
                xfer_dir_rd <= fields.dir_rd;
              end
            end
          end
        end
        ST_WAIT: begin
          if (accept_rsp) begin
            ev_cerr_set <= err_hit;
            ev_cerr_clr <= !err_hit;
            if (timed_out) begin
              ev_cto  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (kind_q == RSP_SHORT_BUSY) begin
              busy_flag <= 1'b1;
              state_q   <= ST_BUSY;
            end else begin
              ev_cc   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_BUSY: begin
          if (!card_busy) begin
            busy_flag <= 1'b0;
            ev_cc     <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_inhibit = (state_q != ST_IDLE);

endmodule

// File: rtl/cmd_issue_chk.sv
module cmd_issue_chk (
  input logic         clk,
  input logic         rst,
  input logic         cmd_wr,
  input logic [31:0]  cmd_wdata,
  input logic         init_mode,
  input logic         rsp_valid,
  input logic         card_busy,
  input logic [31:0]  cmd_q,
  input logic         card_req,
  input logic [127:0] resp_words,
  input logic         xfer_start,
  input logic         busy_flag,
  input logic         cmd_inhibit,
  input logic         ev_cc,
  input logic         ev_cto,
  input logic         ev_cerr_set,
  input logic         ev_cerr_clr
);

  AST_WRITE_WHILE_BUSY_DROPPED: assert property (@(posedge clk) disable iff (rst)
    cmd_inhibit |=> $stable(cmd_q)); // R1

  AST_REQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    card_req |-> $past(cmd_wr)); // R2

  AST_INIT_SHORTCUT: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_inhibit && init_mode && cmd_wdata[29:24] == 6'd0)
      |=> (ev_cc && !card_req && !cmd_inhibit)); // R3

  AST_RESP_ONLY_ON_ANSWER: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> $stable(resp_words)); // R5

  AST_CC_CTO_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ev_cc && ev_cto)); // R6

  AST_BUSY_HOLDS_CC: assert property (@(posedge clk) disable iff (rst)
    (busy_flag && card_busy) |=> (busy_flag && !ev_cc)); // R8

  AST_CERR_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !(ev_cerr_set && ev_cerr_clr)); // R9

  AST_XFER_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> card_req); // R10

endmodule

bind cmd_issue_ctrl cmd_issue_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_wr      (cmd_wr),
  .cmd_wdata   (cmd_wdata),
  .init_mode   (init_mode),
  .rsp_valid   (rsp_valid),
  .card_busy   (card_busy),
  .cmd_q       (cmd_q),
  .card_req    (card_req),
  .resp_words  (resp_words),
  .xfer_start  (xfer_start),
  .busy_flag   (busy_flag),
  .cmd_inhibit (cmd_inhibit),
  .ev_cc       (ev_cc),
  .ev_cto      (ev_cto),
  .ev_cerr_set (ev_cerr_set),
  .ev_cerr_clr (ev_cerr_clr)
);

// File: tb/sim_cmd_issue_ctrl.sv
module sim_cmd_issue_ctrl;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_wr = 1'b0;
  logic [31:0]  cmd_wdata = '0;
  logic [31:0]  arg_in = '0;
  logic [31:0]  err_en = '0;
  logic         init_mode = 1'b0;
  logic         rsp_valid = 1'b0;
  logic [4:0]   rsp_count = '0;
  logic [127:0] rsp_data = '0;
  logic         card_busy = 1'b0;
  logic [31:0]  cmd_q;
  logic         card_req;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic [127:0] resp_words;
  logic         xfer_start, xfer_dir_rd, busy_flag, cmd_inhibit;
  logic         ev_cc, ev_cto, ev_cerr_set, ev_cerr_clr;

  int checks = 0;
  int errs   = 0;
  logic [127:0] exp_resp = '0;
  logic [31:0]  exp_cmdq = '0;
  logic         exp_dir  = 1'b0;

  always #4 clk = ~clk;

  cmd_issue_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .arg_in(arg_in), .err_en(err_en), .init_mode(init_mode),
    .rsp_valid(rsp_valid), .rsp_count(rsp_count), .rsp_data(rsp_data),
    .card_busy(card_busy), .cmd_q(cmd_q), .card_req(card_req),
    .card_idx(card_idx), .card_arg(card_arg), .resp_words(resp_words),
    .xfer_start(xfer_start), .xfer_dir_rd(xfer_dir_rd), .busy_flag(busy_flag),
    .cmd_inhibit(cmd_inhibit), .ev_cc(ev_cc), .ev_cto(ev_cto),
    .ev_cerr_set(ev_cerr_set), .ev_cerr_clr(ev_cerr_clr)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_timeout(input logic [1:0] kind, input int cnt);
    if (kind == 2'd1) return cnt < 16;
    if (kind >= 2'd2) return cnt < 4;
    return 1'b0;
  endfunction

  function automatic logic exp_cerr(input logic [5:0] idx, input logic [1:0] kind,
                                    input int cnt, input logic [127:0] d,
                                    input logic [31:0] en);
    logic [31:0] w;
    w = d[127:96];
    if (kind < 2'd2 || cnt < 4) return 1'b0;
    if (idx == 6'd41 || idx == 6'd8) return 1'b0;
    if (idx == 6'd3) return |({16'h0, w[15:0]} & 32'h0000_0E00 & en);
    return |(w & 32'hFDF9_8000 & en);
  endfunction

  task automatic write_cmd(input logic [31:0] w);
    cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic respond(input int cnt, input logic [127:0] d);
    rsp_valid = 1'b1; rsp_count = 5'(cnt); rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [1:0] kind, input logic dp,
                         input logic dir, input logic init, input int cnt,
                         input logic [127:0] d, input logic [31:0] en,
                         input bit stray, input bit overlap, input int hold);
    logic [31:0] w;
    logic        to;
    logic        ce;
    w = $urandom;
    w[29:24] = idx; w[21] = dp; w[17:16] = kind; w[4] = dir;
    init_mode = init; arg_in = $urandom; err_en = en;
    write_cmd(w);
    exp_cmdq = w & 32'h3FFB_0037;
    chk("R1 cmd_q", cmd_q, exp_cmdq);
    if (init && idx == 6'd0) begin
      chk("R3 ev_cc", ev_cc, 1); chk("R3 card_req", card_req, 0);
      chk("R3 cmd_inhibit", cmd_inhibit, 0);
      @(negedge clk);
      return;
    end
    chk("R2 card_req", card_req, 1); chk("R2 card_idx", card_idx, idx);
    chk("R2 card_arg", card_arg, arg_in); chk("R2 cmd_inhibit", cmd_inhibit, 1);
    chk("R10 xfer_start", xfer_start, dp);
    if (dp) exp_dir = dir;
    chk("R10 xfer_dir_rd", xfer_dir_rd, exp_dir);
    if (stray) begin
      write_cmd(~w);
      chk("R1 ignored write cmd_q", cmd_q, exp_cmdq);
      chk("R1 ignored write card_req", card_req, 0);
    end
    card_busy = (kind == 2'd3);
    respond(cnt, d);
    to = exp_timeout(kind, cnt);
    ce = exp_cerr(idx, kind, cnt, d, en);
    if (!to) begin
      if (kind == 2'd1) exp_resp = d;
      else if (kind >= 2'd2) exp_resp[31:0] = d[127:96];
    end
    chk("R4/R5 resp_words", resp_words, exp_resp);
    chk("R6 ev_cto", ev_cto, to);
    chk("R9 ev_cerr_set", ev_cerr_set, ce);
    chk("R9 ev_cerr_clr", ev_cerr_clr, !ce);
    if (to || kind != 2'd3) begin
      chk("R7 ev_cc", ev_cc, !to);
      chk("R7 cmd_inhibit", cmd_inhibit, 0);
      card_busy = 1'b0;
    end else begin
      chk("R8 busy_flag", busy_flag, 1); chk("R8 ev_cc held", ev_cc, 0);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk("R8 busy hold", {busy_flag, ev_cc}, 2'b10);
      end
      card_busy = 1'b0;
      if (overlap) begin
        write_cmd(~w);
      end else begin
        @(negedge clk);
      end
      chk("R8 ev_cc on release", ev_cc, 1);
      chk("R8 busy_flag low", busy_flag, 0);
      chk("R8 cmd_inhibit low", cmd_inhibit, 0);
      chk("R1 overlap write dropped", cmd_q, exp_cmdq);
      @(negedge clk);
      chk("R1 no request after overlap", card_req, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset card_req", card_req, 0);
    chk("R1 reset cmd_inhibit", cmd_inhibit, 0);
    chk("R4 reset resp_words", resp_words, 0);
    chk("R8 reset busy_flag", busy_flag, 0);
    // directed corner cases
    run_cmd(6'd2, 2'd1, 1'b0, 1'b0, 1'b0, 16, {4{32'hA1B2_C3D4}} ^ 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677,
            32'hFFFF_FFFF, 0, 0, 0);                                  // R4 full long
    run_cmd(6'd9, 2'd1, 1'b0, 1'b0, 1'b0, 15, '1, 32'hFFFF_FFFF, 0, 0, 0); // R6 long short by one
    run_cmd(6'd17, 2'd2, 1'b1, 1'b1, 1'b0, 4, {32'h8000_0000, 96'h0}, 32'hFFFF_FFFF, 0, 0, 0); // R9 std hit
    run_cmd(6'd17, 2'd2, 1'b1, 1'b0, 1'b0, 4, {32'h8000_0000, 96'h0}, 32'h7FFF_FFFF, 0, 0, 0); // R9 gated off
    run_cmd(6'd3, 2'd2, 1'b0, 1'b0, 1'b0, 4, {32'hFFFF_0200, 96'h0}, 32'hFFFF_FFFF, 0, 0, 0);  // R9 idx3 hit
    run_cmd(6'd41, 2'd2, 1'b0, 1'b0, 1'b0, 4, '1, 32'hFFFF_FFFF, 0, 0, 0);  // R9 never checked
    run_cmd(6'd8, 2'd2, 1'b0, 1'b0, 1'b0, 3, '1, 32'hFFFF_FFFF, 1, 0, 0);   // R6 short timeout
    run_cmd(6'd0, 2'd0, 1'b1, 1'b1, 1'b1, 0, '0, 32'h0, 0, 0, 0);          // R3 bypass
    run_cmd(6'd0, 2'd0, 1'b0, 1'b0, 1'b0, 0, '0, 32'h0, 0, 0, 0);          // R7 idx0 not init
    run_cmd(6'd7, 2'd3, 1'b0, 1'b0, 1'b0, 4, {32'h0000_8000, 96'h0}, 32'hFFFF_FFFF, 0, 1, 3); // R8 overlap
    run_cmd(6'd7, 2'd3, 1'b0, 1'b0, 1'b0, 4, '0, 32'h0, 0, 0, 0);          // R8 immediate release
    // random
    for (int it = 0; it < 300; it++) begin
      logic [5:0] idx;
      int         sel;
      int         cnt;
      logic [31:0] en;
      sel = $urandom % 8;
      case (sel)
        0: idx = 6'd0;  1: idx = 6'd3;
        2: idx = 6'd8;  3: idx = 6'd41;
        default: idx = 6'($urandom % 64);
      endcase
      cnt = ($urandom % 3 == 0) ? int'($urandom % 17) : 16 + int'($urandom % 4);
      case ($urandom % 3)
        0: en = 32'hFFFF_FFFF;
        1: en = 32'h0;
        default: en = $urandom;
      endcase
      run_cmd(idx, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
              ($urandom % 4) == 0, cnt, {$urandom, $urandom, $urandom, $urandom},
              en, ($urandom % 4) == 0, ($urandom % 2) == 1, int'($urandom % 4));
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule